// File: doc/BRIEF.md
# Receive Endpoint Data Toggle Tracker

This block holds the expected data toggle (DATA0 or DATA1) of every receive endpoint of a USB function or host controller, one bit per endpoint. Each time a packet finishes, the receive path presents the endpoint number, the data PID it carried and whether its CRC was good. The tracker compares the PID against that endpoint's stored toggle and returns a keep-or-drop verdict one clock later. A dropped packet must be discarded silently by the consumer, and its payload is never delivered.

Only an accepted packet advances the toggle. Each endpoint's bit lives in its own storage and is updated by its own logic, so traffic on one endpoint can never move the toggle of another. Software can force a toggle through a write port. The write changes the toggle only when the enable bit and the value are presented in the same write. A per-endpoint clear strobe, used for events such as configuration or clear-halt, returns one endpoint to DATA0. All toggles are visible at all times as a bit map.

Top module: `rx_toggle_tracker`

## Requirements
- R1: After reset every bit of `toggle_map` is 0 (DATA0) and `verdict_valid` is low.
- R2: A strobe with a good CRC whose data PID matches the endpoint's toggle is accepted. At the next clock edge `verdict_accept` goes high and that endpoint's toggle inverts. The toggle encoding is bit value 0 for DATA0 and 1 for DATA1.
- R3: A strobe with a good CRC whose data PID differs from the endpoint's toggle is discarded, with `verdict_accept` low, and the toggle is left unchanged.
- R4: A strobe with a bad CRC is discarded and leaves the toggle unchanged.
- R5: Only PID 4'b0011 (DATA0) and PID 4'b1011 (DATA1) count as data PIDs. A strobe carrying any other PID is discarded and leaves the toggle unchanged.
- R6: A packet, software write or clear on one endpoint never changes the toggle of any other endpoint.
- R7: A write with `sw_tgl_we`=1 sets the addressed toggle to `sw_tgl_val` at the next edge. A write with `sw_tgl_we`=0 leaves it unchanged.
- R8: When an enabled software write and an accepted packet target the same endpoint in the same cycle, the written value wins. The verdict still reports the acceptance.
- R9: `ep_clr_req` returns endpoint `ep_clr_idx` to DATA0 at the next edge. This takes priority over a software write and a packet in the same cycle.
- R10: `verdict_valid` is high for exactly the one cycle after each `pkt_done` cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | Packet-complete strobe |
| pkt_ep | input | 4 | Endpoint number of the finished packet |
| pkt_pid | input | 4 | PID received with the packet |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| sw_wr | input | 1 | Software write strobe |
| sw_ep | input | 4 | Endpoint addressed by the write |
| sw_tgl_we | input | 1 | Toggle write-enable bit of the write |
| sw_tgl_val | input | 1 | Toggle value bit of the write |
| ep_clr_req | input | 1 | Per-endpoint clear strobe |
| ep_clr_idx | input | 4 | Endpoint to clear |
| verdict_valid | output | 1 | Verdict present for the previous strobe |
| verdict_accept | output | 1 | 1 = deliver the packet, 0 = discard |
| toggle_map | output | 16 | Current toggle of every endpoint |

## Verification
The assertions assume that every input is driven to a known value while reset is released. They also assume that each input strobe is a single-cycle qualifier whose address and data fields are only meaningful while it is high. Because of this, the properties only look at the index fields in cycles where the matching strobe is set. The bench drives every input on the falling clock edge and returns all strobes to zero after each step. Collisions are only created on purpose, in the scenarios for R8 and R9.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  localparam int PID_W = 4;
  localparam logic [PID_W-1:0] PID_DATA0 = 4'b0011;
  localparam logic [PID_W-1:0] PID_DATA1 = 4'b1011;

  typedef struct packed {
    logic is_data;
    logic data_bit;
  } pid_class_t;

  function automatic pid_class_t classify_pid(input logic [PID_W-1:0] pid);
    pid_class_t c;
    c.is_data  = (pid == PID_DATA0) || (pid == PID_DATA1);
    c.data_bit = (pid == PID_DATA1);
    return c;
  endfunction

  // Priority: clear, then software write, then accepted packet.
  function automatic logic next_toggle(input logic cur, input logic clr,
                                       input logic sw_hit, input logic sw_val,
                                       input logic acc_hit);
    if (clr)          return 1'b0;
    else if (sw_hit)  return sw_val;
    else if (acc_hit) return ~cur;
    else              return cur;
  endfunction
endpackage

// File: rtl/tgl_pid_decode.sv
module tgl_pid_decode
  import tgl_pkg::*;
(
  input  logic [PID_W-1:0] pid,
  output logic             is_data,
  output logic             data_bit
);
  pid_class_t cls;
  always_comb begin
    cls      = classify_pid(pid);
    is_data  = cls.is_data;
    data_bit = cls.data_bit;
  end
endmodule

// File: rtl/tgl_bank.sv
module tgl_bank
  import tgl_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_evt,
  input  logic [EP_W-1:0]   acc_ep,
  input  logic              sw_evt,
  input  logic [EP_W-1:0]   sw_ep,
  input  logic              sw_val,
  input  logic              clr_evt,
  input  logic [EP_W-1:0]   clr_ep,
  output logic [NUM_EP-1:0] tgl_q
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit_acc, hit_sw, hit_clr;
    assign hit_acc = acc_evt && (acc_ep == EP_W'(i));
    assign hit_sw  = sw_evt  && (sw_ep  == EP_W'(i));
    assign hit_clr = clr_evt && (clr_ep == EP_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) tgl_q[i] <= 1'b0;
      else        tgl_q[i] <= next_toggle(tgl_q[i], hit_clr, hit_sw, sw_val, hit_acc);
    end
  end
endmodule

// File: rtl/rx_toggle_tracker.sv
module rx_toggle_tracker
  import tgl_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic [PID_W-1:0]  pkt_pid,
  input  logic              pkt_crc_ok,
  input  logic              sw_wr,
  input  logic [EP_W-1:0]   sw_ep,
  input  logic              sw_tgl_we,
  input  logic              sw_tgl_val,
  input  logic              ep_clr_req,
  input  logic [EP_W-1:0]   ep_clr_idx,
  output logic              verdict_valid,
  output logic              verdict_accept,
  output logic [NUM_EP-1:0] toggle_map
);
  logic pid_is_data, pid_bit, expect_bit;
  logic accept_evt, sw_force_evt;

  tgl_pid_decode u_dec (
    .pid      (pkt_pid),
    .is_data  (pid_is_data),
    .data_bit (pid_bit)
  );

  assign expect_bit   = toggle_map[pkt_ep];
  assign accept_evt   = pkt_done && pkt_crc_ok && pid_is_data && (pid_bit == expect_bit);
  assign sw_force_evt = sw_wr && sw_tgl_we;

  tgl_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_evt (accept_evt),
    .acc_ep  (pkt_ep),
    .sw_evt  (sw_force_evt),
    .sw_ep   (sw_ep),
    .sw_val  (sw_tgl_val),
    .clr_evt (ep_clr_req),
    .clr_ep  (ep_clr_idx),
    .tgl_q   (toggle_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid  <= pkt_done;
      verdict_accept <= accept_evt;
    end
  end
endmodule

// File: rtl/rx_toggle_tracker_chk.sv
module rx_toggle_tracker_chk #(
  parameter int NUM_EP = 16,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_done,
  input logic [EP_W-1:0]   pkt_ep,
  input logic [3:0]        pkt_pid,
  input logic              pkt_crc_ok,
  input logic              sw_wr,
  input logic [EP_W-1:0]   sw_ep,
  input logic              sw_tgl_we,
  input logic              sw_tgl_val,
  input logic              ep_clr_req,
  input logic [EP_W-1:0]   ep_clr_idx,
  input logic              verdict_valid,
  input logic              verdict_accept,
  input logic [NUM_EP-1:0] toggle_map
);
  logic pid_ok, match, sw_clash, clr_clash;
  assign pid_ok    = (pkt_pid == 4'b0011) || (pkt_pid == 4'b1011);
  assign match     = pid_ok && (pkt_pid[3] == toggle_map[pkt_ep]);
  assign sw_clash  = sw_wr && sw_tgl_we && (sw_ep == pkt_ep);
  assign clr_clash = ep_clr_req && (ep_clr_idx == pkt_ep);

  p_valid_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> verdict_valid);
  p_valid_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> !verdict_valid);
  p_accept_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_crc_ok && match && !sw_clash && !clr_clash)
      |=> verdict_accept && (toggle_map[$past(pkt_ep)] == !$past(toggle_map[pkt_ep])));
  p_mismatch_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pid_ok && !match) |=> !verdict_accept);
  p_badcrc_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !pkt_crc_ok) |=> !verdict_accept);
  p_nondata_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !pid_ok) |=> !verdict_accept);
  p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !(sw_wr && sw_tgl_we) && !ep_clr_req) |=> $stable(toggle_map));
  p_sw_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_tgl_we && !(ep_clr_req && ep_clr_idx == sw_ep))
      |=> toggle_map[$past(sw_ep)] == $past(sw_tgl_val));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ep_clr_req |=> !toggle_map[$past(ep_clr_idx)]);
  p_accept_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_accept |-> verdict_valid);
endmodule

bind rx_toggle_tracker rx_toggle_tracker_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/rx_toggle_tracker_test.sv
module rx_toggle_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_done = 1'b0;
  logic [3:0]  pkt_ep = '0;
  logic [3:0]  pkt_pid = '0;
  logic        pkt_crc_ok = 1'b0;
  logic        sw_wr = 1'b0;
  logic [3:0]  sw_ep = '0;
  logic        sw_tgl_we = 1'b0;
  logic        sw_tgl_val = 1'b0;
  logic        ep_clr_req = 1'b0;
  logic [3:0]  ep_clr_idx = '0;
  logic        verdict_valid, verdict_accept;
  logic [15:0] toggle_map;

  logic [15:0] model;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_toggle_tracker uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock of stimulus, then compare against the bench model.
  task automatic step(input string req,
                      input bit pd, input logic [3:0] ep, input logic [3:0] pid, input bit crc,
                      input bit swr, input logic [3:0] sep, input bit we, input bit val,
                      input bit cr, input logic [3:0] cidx);
    bit exp_acc;
    bit data0, data1;
    @(negedge clk);
    pkt_done = pd; pkt_ep = ep; pkt_pid = pid; pkt_crc_ok = crc;
    sw_wr = swr; sw_ep = sep; sw_tgl_we = we; sw_tgl_val = val;
    ep_clr_req = cr; ep_clr_idx = cidx;
    data0 = (pid == 4'h3);
    data1 = (pid == 4'hB);
    exp_acc = pd && crc && ((data0 && !model[ep]) || (data1 && model[ep]));
    if (exp_acc) model[ep] = ~model[ep];
    if (swr && we) model[sep] = val;
    if (cr) model[cidx] = 1'b0;
    @(negedge clk);
    pkt_done = 0; sw_wr = 0; sw_tgl_we = 0; ep_clr_req = 0;
    chk(verdict_valid == pd, {req, " verdict_valid"}, verdict_valid, pd);
    if (pd) chk(verdict_accept == exp_acc, {req, " verdict_accept"}, verdict_accept, exp_acc);
    chk(toggle_map == model, {req, " toggle_map"}, toggle_map, model);
  endtask

  task automatic pkt(input string req, input logic [3:0] ep, input logic [3:0] pid, input bit crc);
    step(req, 1, ep, pid, crc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_r1();
    chk(toggle_map == 16'h0, "R1 toggles", toggle_map, 0);
    chk(verdict_valid == 1'b0, "R1 valid", verdict_valid, 0);
  endtask

  task automatic t_accept_r2();
    pkt("R2 data0 on ep3", 4'd3, 4'h3, 1);
    pkt("R2 data1 on ep3", 4'd3, 4'hB, 1);
    pkt("R2 data0 again ep3", 4'd3, 4'h3, 1);
  endtask

  task automatic t_mismatch_r3();
    pkt("R3 repeat data0 ep3", 4'd3, 4'h3, 1);
    pkt("R3 data1 on fresh ep5", 4'd5, 4'hB, 1);
  endtask

  task automatic t_badcrc_r4();
    pkt("R4 bad crc matching pid", 4'd7, 4'h3, 0);
    pkt("R4 bad crc other pid", 4'd7, 4'hB, 0);
  endtask

  task automatic t_nondata_r5();
    pkt("R5 pid 0x2", 4'd8, 4'h2, 1);
    pkt("R5 pid 0xA", 4'd8, 4'hA, 1);
    pkt("R5 pid 0x7", 4'd8, 4'h7, 1);
    pkt("R5 pid 0xF", 4'd8, 4'hF, 1);
  endtask

  task automatic t_interleave_r6();
    for (int k = 0; k < 24; k++) begin
      logic [3:0] e;
      e = 4'((k * 5) % 16);
      pkt("R6 interleaved", e, model[e] ? 4'hB : 4'h3, 1);
    end
    pkt("R6 ep15 top", 4'd15, model[15] ? 4'hB : 4'h3, 1);
    pkt("R6 ep0 bottom", 4'd0, model[0] ? 4'hB : 4'h3, 1);
  endtask

  task automatic t_sw_r7();
    step("R7 write without enable", 0, 0, 0, 0, 1, 4'd9, 0, 1, 0, 0);
    step("R7 write set ep9", 0, 0, 0, 0, 1, 4'd9, 1, 1, 0, 0);
    step("R7 write clear ep9", 0, 0, 0, 0, 1, 4'd9, 1, 0, 0, 0);
    step("R7 write set ep2", 0, 0, 0, 0, 1, 4'd2, 1, 1, 0, 0);
    pkt("R7 data1 now accepted ep2", 4'd2, 4'hB, 1);
  endtask

  task automatic t_collide_r8();
    step("R8 sw clear vs accept ep4", 1, 4'd4, model[4] ? 4'hB : 4'h3, 1,
         1, 4'd4, 1, model[4], 0, 0);
    step("R8 sw without enable vs accept", 1, 4'd4, model[4] ? 4'hB : 4'h3, 1,
         1, 4'd4, 0, ~model[4], 0, 0);
    step("R8 sw other ep alongside accept", 1, 4'd6, model[6] ? 4'hB : 4'h3, 1,
         1, 4'd11, 1, 1, 0, 0);
  endtask

  task automatic t_clear_r9();
    step("R9 set ep12", 0, 0, 0, 0, 1, 4'd12, 1, 1, 0, 0);
    step("R9 clear ep12", 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd12);
    step("R9 set ep12 again", 0, 0, 0, 0, 1, 4'd12, 1, 1, 0, 0);
    step("R9 clear beats sw and pkt", 1, 4'd12, 4'hB, 1, 1, 4'd12, 1, 1, 1, 4'd12);
  endtask

  task automatic t_valid_r10();
    step("R10 idle cycle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    pkt("R10 lone strobe", 4'd1, 4'h3, 1);
    step("R10 idle after strobe", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_reset_r1();
    t_accept_r2();
    t_mismatch_r3();
    t_badcrc_r4();
    t_nondata_r5();
    t_interleave_r6();
    t_sw_r7();
    t_collide_r8();
    t_clear_r9();
    t_valid_r10();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule